// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block sits behind a CAN receiver and decides, for each received frame, whether the frame is kept for the host or discarded. The receiver presents the four identifier bytes of the frame, a flag that tells whether the identifier is extended, and a one-cycle valid strobe. The filter compares the identifier against two programmable banks. Each bank holds four acceptance-code bytes and four mask bytes. One clock later it raises either an accept pulse, together with the number of the bank that hit, or a drop pulse.

A mask bit set to 1 makes the identifier bit at that position a don't-care. A mask bit of 0 forces that bit to equal the code bit. A standard-identifier frame is compared on bytes 0 and 1 of each bank only. An extended frame uses all four bytes. The code and mask registers can be read at any time. They can be written only while the controller is in initialization mode, which means both the request and the acknowledge inputs are high.

Top module: `canflt_top`

## Requirements
- R1: After reset every code and mask register reads 0, and rxAccept, rxDrop and hitBank are 0.
- R2: A configuration write takes effect only when cfgWrEn, initReq and initAck are all 1. A write attempted while initReq or initAck is 0 leaves the register unchanged.
- R3: cfgRdData shows the register selected by cfgSel (0 = code, 1 = mask) and cfgAddr at all times, in the same cycle and with no condition.
- R4: For each bank, identifier byte n is compared with code byte n, bit by bit. A position whose mask bit is 1 is ignored. A position whose mask bit is 0 must match exactly.
- R5: When idExt = 1, bytes 0 to 3 of a bank must all match for that bank to hit.
- R6: When idExt = 0, only bytes 0 and 1 of a bank are compared, and any value in identifier bytes 2 and 3 has no effect on the decision.
- R7: A frame is accepted if at least one bank hits. hitBank then gives the lowest-numbered bank that hit. On a drop, hitBank reads 0.
- R8: Exactly one of rxAccept and rxDrop pulses for one cycle, on the clock after the cycle in which idValid is 1. Neither pulses in any other cycle.
- R9: cfgAddr 0 to 3 address bytes 0 to 3 of bank 0, and cfgAddr 4 to 7 address bytes 0 to 3 of bank 1. Identifier byte n is carried on idBytes[8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| initReq | input | 1 | Initialization mode requested |
| initAck | input | 1 | Initialization mode acknowledged |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | Register class: 0 code, 1 mask |
| cfgAddr | input | 3 | Register byte address |
| cfgWrData | input | 8 | Write data |
| cfgRdData | output | 8 | Read data of the addressed register |
| idBytes | input | 32 | Received identifier, byte n at bits 8n+7:8n |
| idExt | input | 1 | 1 = extended identifier |
| idValid | input | 1 | Identifier present this cycle |
| rxAccept | output | 1 | Frame accepted, one-cycle pulse |
| rxDrop | output | 1 | Frame dropped, one-cycle pulse |
| hitBank | output | 1 | Lowest bank that matched |

## Verification
The bench targets the following corner cases:

- **Standard frame with junk in bytes 2 and 3.** A filter that ignored the idExt flag would drop this frame.
- **Extended frame that differs only in byte 3.** A filter that treated every frame as standard would accept it.
- **Both banks matching at once.** The expected hitBank is 0; a priority error would show bank 1.
- **Single-bit mismatches on masked and unmasked positions.** These expose an inverted mask polarity or a mask applied to the wrong byte.
- **Writes outside initialization mode.** These are read back afterwards, so a missing gate on initAck or initReq shows up as changed register contents.

// File: rtl/canflt_pkg.sv
package canflt_pkg;
  typedef struct packed {
    logic wrCode;
    logic wrMask;
    logic sample;
  } ctrlStrb_t;
endpackage

// File: rtl/canflt_ctrl.sv
module canflt_ctrl
  import canflt_pkg::*;
(
  input  logic      initReq,
  input  logic      initAck,
  input  logic      cfgWrEn,
  input  logic      cfgSel,
  input  logic      idValid,
  output ctrlStrb_t strb
);
  logic inInit;

  always_comb begin
    inInit      = initReq & initAck;
    strb.wrCode = cfgWrEn & inInit & ~cfgSel;
    strb.wrMask = cfgWrEn & inInit & cfgSel;
    strb.sample = idValid;
  end
endmodule

// File: rtl/canflt_dp.sv
module canflt_dp
  import canflt_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_BYTES = 4,
  parameter int STD_BYTES = 2,
  parameter int BYTE_W = 8,
  localparam int TOTAL = NUM_BANKS * BANK_BYTES,
  localparam int AW = $clog2(TOTAL),
  localparam int HW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int IDW = BANK_BYTES * BYTE_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              cfgSel,
  input  logic [AW-1:0]     cfgAddr,
  input  logic [BYTE_W-1:0] cfgWrData,
  output logic [BYTE_W-1:0] cfgRdData,
  input  logic [IDW-1:0]    idBytes,
  input  logic              idExt,
  output logic              rxAccept,
  output logic              rxDrop,
  output logic [HW-1:0]     hitBank,
  output logic [TOTAL*BYTE_W-1:0] codeFlat,
  output logic [TOTAL*BYTE_W-1:0] maskFlat
);
  logic [BYTE_W-1:0] codeQ [TOTAL];
  logic [BYTE_W-1:0] maskQ [TOTAL];
  logic [NUM_BANKS-1:0] bankHit;
  logic [HW-1:0] firstHit;

  genvar gi, gb, gk;
  generate
    for (gi = 0; gi < TOTAL; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          codeQ[gi] <= '0;
          maskQ[gi] <= '0;
        end else begin
          if (strb.wrCode && cfgAddr == AW'(gi)) codeQ[gi] <= cfgWrData;
          if (strb.wrMask && cfgAddr == AW'(gi)) maskQ[gi] <= cfgWrData;
        end
      end
      assign codeFlat[gi*BYTE_W +: BYTE_W] = codeQ[gi];
      assign maskFlat[gi*BYTE_W +: BYTE_W] = maskQ[gi];
    end

    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      logic [BANK_BYTES-1:0] byteOk;
      for (gk = 0; gk < BANK_BYTES; gk++) begin : g_byte
        localparam int IDX = gb * BANK_BYTES + gk;
        logic [BYTE_W-1:0] diff;
        assign diff = (idBytes[gk*BYTE_W +: BYTE_W] ^ codeQ[IDX]) & ~maskQ[IDX];
        if (gk < STD_BYTES) begin : g_always
          assign byteOk[gk] = ~|diff;
        end else begin : g_extOnly
          assign byteOk[gk] = ~idExt | ~|diff;
        end
      end
      assign bankHit[gb] = &byteOk;
    end
  endgenerate

  always_comb begin
    cfgRdData = cfgSel ? maskQ[cfgAddr] : codeQ[cfgAddr];
    firstHit = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (bankHit[b]) firstHit = HW'(b);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxAccept <= 1'b0;
      rxDrop   <= 1'b0;
      hitBank  <= '0;
    end else begin
      rxAccept <= strb.sample & (|bankHit);
      rxDrop   <= strb.sample & ~(|bankHit);
      if (strb.sample) hitBank <= (|bankHit) ? firstHit : '0;
    end
  end
endmodule

// File: rtl/canflt_top.sv
module canflt_top
  import canflt_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_BYTES = 4,
  parameter int STD_BYTES = 2,
  parameter int BYTE_W = 8,
  localparam int TOTAL = NUM_BANKS * BANK_BYTES,
  localparam int AW = $clog2(TOTAL),
  localparam int HW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int IDW = BANK_BYTES * BYTE_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              initReq,
  input  logic              initAck,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [AW-1:0]     cfgAddr,
  input  logic [BYTE_W-1:0] cfgWrData,
  output logic [BYTE_W-1:0] cfgRdData,
  input  logic [IDW-1:0]    idBytes,
  input  logic              idExt,
  input  logic              idValid,
  output logic              rxAccept,
  output logic              rxDrop,
  output logic [HW-1:0]     hitBank
);
  ctrlStrb_t strb;
  logic [TOTAL*BYTE_W-1:0] codeFlat;
  logic [TOTAL*BYTE_W-1:0] maskFlat;

  canflt_ctrl uCtrl (
    .initReq(initReq), .initAck(initAck), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .idValid(idValid), .strb(strb)
  );

  canflt_dp #(
    .NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES),
    .STD_BYTES(STD_BYTES), .BYTE_W(BYTE_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgSel(cfgSel),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .idBytes(idBytes), .idExt(idExt), .rxAccept(rxAccept),
    .rxDrop(rxDrop), .hitBank(hitBank),
    .codeFlat(codeFlat), .maskFlat(maskFlat)
  );
endmodule

// File: rtl/canflt_chk.sv
module canflt_chk #(
  parameter int FW = 64,
  parameter int HW = 1
)(
  input logic          clk,
  input logic          rstN,
  input logic          initReq,
  input logic          initAck,
  input logic          idValid,
  input logic          rxAccept,
  input logic          rxDrop,
  input logic [HW-1:0] hitBank,
  input logic [FW-1:0] codeFlat,
  input logic [FW-1:0] maskFlat
);
  // R8
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rxAccept && rxDrop));

  // R8
  valid_answered_chk: assert property (@(posedge clk) disable iff (!rstN)
    idValid |=> (rxAccept || rxDrop));

  // R8
  no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !idValid |=> !(rxAccept || rxDrop));

  // R2
  code_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(initReq && initAck) |=> $stable(codeFlat));

  // R2
  mask_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(initReq && initAck) |=> $stable(maskFlat));

  // R7
  drop_hit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDrop |-> (hitBank == '0));
endmodule

bind canflt_top canflt_chk #(.FW(TOTAL*BYTE_W), .HW(HW)) uChk (
  .clk(clk), .rstN(rstN), .initReq(initReq), .initAck(initAck),
  .idValid(idValid), .rxAccept(rxAccept), .rxDrop(rxDrop),
  .hitBank(hitBank), .codeFlat(uDp.codeFlat), .maskFlat(uDp.maskFlat)
);

// File: tb/tb_canflt_top.sv
module tb_canflt_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initReq = 1'b0, initAck = 1'b0, cfgWrEn = 1'b0, cfgSel = 1'b0;
  logic [2:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic [31:0] idBytes = '0;
  logic idExt = 1'b0, idValid = 1'b0;
  logic rxAccept, rxDrop;
  logic [0:0] hitBank;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] shCode [8];
  logic [7:0] shMask [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  canflt_top dut (
    .clk(clk), .rstN(rstN), .initReq(initReq), .initAck(initAck),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .idBytes(idBytes),
    .idExt(idExt), .idValid(idValid), .rxAccept(rxAccept),
    .rxDrop(rxDrop), .hitBank(hitBank)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic bankMatch(input int b, input logic [31:0] id, input logic ext);
    logic ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if (k < 2 || ext)
        if (((id[k*8 +: 8] ^ shCode[b*4+k]) & ~shMask[b*4+k]) != 8'h00) ok = 1'b0;
    end
    return ok;
  endfunction

  // write one register; the shadow copy follows only in initialization mode
  task automatic wrReg(input logic sel, input int addr, input logic [7:0] data,
                       input logic rq, input logic ak);
    @(negedge clk);
    initReq = rq; initAck = ak; cfgWrEn = 1'b1;
    cfgSel = sel; cfgAddr = 3'(addr); cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (rq && ak) begin
      if (sel) shMask[addr] = data; else shCode[addr] = data;
    end
  endtask

  task automatic rdCheck(input string req, input logic sel, input int addr);
    cfgSel = sel; cfgAddr = 3'(addr);
    #1;
    check(req, 32'(cfgRdData), 32'(sel ? shMask[addr] : shCode[addr]));
  endtask

  task automatic frame(input string req, input logic [31:0] id, input logic ext);
    logic m0, m1, acc;
    logic [0:0] hb;
    m0 = bankMatch(0, id, ext);
    m1 = bankMatch(1, id, ext);
    acc = m0 | m1;
    hb = (!m0 && m1) ? 1'b1 : 1'b0;
    @(negedge clk);
    idBytes = id; idExt = ext; idValid = 1'b1;
    @(negedge clk);
    idValid = 1'b0;
    check(req, 32'({rxAccept, rxDrop, hitBank}), 32'({acc, ~acc, hb}));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] id;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin shCode[i] = '0; shMask[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset values
    check("R1 outputs", 32'({rxAccept, rxDrop, hitBank}), 32'd0);
    for (int a = 0; a < 8; a++) begin
      rdCheck("R1 code reset", 1'b0, a);
      rdCheck("R1 mask reset", 1'b1, a);
    end
    // R8: no pulse without valid
    @(negedge clk);
    check("R8 idle", 32'({rxAccept, rxDrop}), 32'd0);

    // R2 / R9: program distinct bytes in init mode
    for (int a = 0; a < 8; a++) begin
      wrReg(1'b0, a, 8'(8'h10 + a), 1'b1, 1'b1);
      wrReg(1'b1, a, 8'h00, 1'b1, 1'b1);
    end
    for (int a = 0; a < 8; a++) rdCheck("R3 R9 readback", 1'b0, a);
    // R2: writes outside init mode are ignored
    wrReg(1'b0, 2, 8'hEE, 1'b1, 1'b0);
    wrReg(1'b1, 5, 8'hEE, 1'b0, 1'b1);
    wrReg(1'b0, 7, 8'hEE, 1'b0, 1'b0);
    rdCheck("R2 ignored code2", 1'b0, 2);
    rdCheck("R2 ignored mask5", 1'b1, 5);
    rdCheck("R2 ignored code7", 1'b0, 7);

    // R9 R5: exact extended match on bank 1 (bytes 0..3 = 14..17)
    frame("R5 R9 ext bank1", 32'h17161514, 1'b1);
    // R5: extended, byte 3 differs -> drop
    frame("R5 ext byte3 miss", 32'h97161514, 1'b1);
    // R6: standard, junk in bytes 2,3 -> bank0 accept
    frame("R6 std ignore hi", 32'hABCD1110, 1'b0);
    frame("R6 std byte1 miss", 32'h00001210, 1'b0);

    // R4: mask bit makes position don't-care
    wrReg(1'b1, 0, 8'h01, 1'b1, 1'b1);
    frame("R4 masked bit", 32'h13121111, 1'b1);
    frame("R4 unmasked bit", 32'h13121112, 1'b1);

    // R7: both banks match -> bank 0 reported
    for (int a = 0; a < 4; a++) wrReg(1'b0, 4 + a, shCode[a], 1'b1, 1'b1);
    frame("R7 both banks", 32'h13121110, 1'b1);
    wrReg(1'b1, 7, 8'hFF, 1'b1, 1'b1);
    frame("R7 only bank1", 32'h55121110, 1'b1);

    // random configuration and frames
    for (int round = 0; round < 20; round++) begin
      for (int a = 0; a < 8; a++) begin
        wrReg(1'b0, a, 8'($urandom), 1'b1, 1'b1);
        wrReg(1'b1, a, 8'($urandom) & 8'($urandom), 1'b1, 1'b1);
      end
      wrReg(1'b0, $urandom_range(0, 7), 8'($urandom), 1'b1, 1'b0);
      for (int a = 0; a < 8; a++) rdCheck("R2 R3 random", 1'b1, a);
      initReq = 1'b0; initAck = 1'b0;
      for (int f = 0; f < 30; f++) begin
        int b;
        b = $urandom_range(0, 1);
        for (int k = 0; k < 4; k++) id[k*8 +: 8] = shCode[b*4+k] ^ (8'($urandom) & shMask[b*4+k]);
        if ($urandom_range(0, 3) == 0) id = id ^ (32'd1 << $urandom_range(0, 31));
        frame("R4 R5 R6 R7 random", id, 1'($urandom));
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule